// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks one of several free-running clock sources, which need not be related in frequency or phase, and drives it onto one output clock. A change of selection never produces a runt pulse on the output. The outgoing source is first shut off during one of its own low phases. Only after that has been seen is the incoming source let through, again starting in one of its own low phases.

Each source has its own gating path. The path holds a short chain of flops clocked on the falling edge of that source. A path only asks to turn on when its code is on the select input and no other path is active or starting up. The output is the OR of every source ANDed with its path's enable.

A status word carries one bit per source. The bit is set only while that source actually reaches the output, so software can poll it until a switch has finished. During a handover the word reads as all zeros. When the block is built with a single source, all switching logic is removed: the source is wired straight through and the status is the constant 1.

Top module: `clk_glitchfree_mux`

## Requirements
- R1: While status bit k is set, `clk_o` follows source k exactly, with the same period and duty cycle.
- R2: When the selection moves between two different sources, the new path only turns on after every other path has fully released. The status therefore passes through all zeros between the two one-hot values.
- R3: Status bit k belongs to select code k (bit 0 to code 0, and so on). At every instant the status has at most one bit set.
- R4: Outside reset, no high or low pulse on `clk_o` is shorter than the shortest half-period among the sources involved in the current and the two previous selections.
- R5: After the select input changes, the status shows the new source within SYNC_STAGES+1 falling edges of the outgoing source, followed by SYNC_STAGES+1 falling edges of the incoming source.
- R6: Writing the code of the source that is already driving the output starts no handover. The status never drops, and the output keeps the same period.
- R7: A select code of N_SRC or above turns on no path. Within SYNC_STAGES+1 falling edges of the old source, the status reads all zeros and `clk_o` is held low.
- R8: Asserting `rst_ni` low clears every path at once, asynchronously: the status reads zero and `clk_o` is low. After release, the selected source comes up with the latency given in R5 and no preceding release.
- R9: With N_SRC = 1 the status reads constantly 1, `clk_o` equals the single source, and the select input has no effect.
- R10: The select input may be rewritten while a handover is still in progress. The last code written is the one that ends up driving the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | N_SRC | Free-running source clocks; bit k is source k |
| rst_ni | input | 1 | Asynchronous active-low reset of all gating paths |
| sel_i | input | SEL_W | Encoded source select, SEL_W = max(1, clog2(N_SRC)) |
| clk_o | output | 1 | Selected, glitch-free output clock |
| status_o | output | N_SRC | One-hot flag of the source now driving `clk_o`; all zero during a handover |

## Verification
The status result of a select write is due within SYNC_STAGES+1 falling edges of the outgoing source plus SYNC_STAGES+1 of the incoming one. With the slowest source at 26 ns, that is at most about 160 ns. The scoreboard therefore compares each queued expectation at the first bench falling edge after a fixed 250 ns wait, and only then measures two output rising edges to confirm the new period. The one-hot check and the pulse-width check are not tied to that deadline: they run on every status change and on every output edge. Select writes and resets are made 0.3 ns after a bench edge, and no source edge ever falls there.

// File: rtl/gfm_pkg.sv
`timescale 1ns/1ps
package gfm_pkg;

   // Upper bound on the number of sources one selector may take.
   localparam int unsigned GFM_MAX_SRC = 32;

   // Width of the encoded select field for a given source count.
   function automatic int unsigned gfm_sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/gfm_sync.sv
`timescale 1ns/1ps
// Falling-edge enable chain of one source path.
module gfm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o,
   output logic busy_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gfm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   // Busy covers every stage: a path that has begun to turn on, or has
   // not yet finished turning off, blocks all other paths.
   assign q_o    = chain_q[STAGES-1];
   assign busy_o = |chain_q;

endmodule

// File: rtl/gfm_path.sv
`timescale 1ns/1ps
// One source path: request decode, enable synchroniser, clock gate.
module gfm_path #(
   parameter int unsigned K      = 0,
   parameter int unsigned SEL_W  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             src_clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             others_busy_i,
   output logic             busy_o,
   output logic             en_o,
   output logic             gclk_o
);

   localparam int unsigned CW = $clog2(STAGES + 2);

   if (K >= (1 << SEL_W)) begin : g_bad_index
      $error("gfm_path: K does not fit the select width");
   end

   logic picked;
   logic req;

   assign picked = (sel_i == SEL_W'(K));
   assign req    = picked && !others_busy_i;

   gfm_sync #(.STAGES(STAGES)) u_sync (
      .clk_i  (src_clk_i),
      .rst_ni (rst_ni),
      .d_i    (req),
      .q_o    (en_o),
      .busy_o (busy_o)
   );

   // en_o only moves on a falling edge, so the AND never cuts a high phase.
   assign gclk_o = src_clk_i & en_o;

   // ---------------------------------------------------------------
   // Checks
   // ---------------------------------------------------------------
   // Counts falling edges in a row on which this path was not selected.
   logic [CW-1:0] off_cnt_q;

   always_ff @(negedge src_clk_i or negedge rst_ni) begin
      if (!rst_ni)               off_cnt_q <= '0;
      else if (picked)           off_cnt_q <= '0;
      else if (off_cnt_q <= CW'(STAGES)) off_cnt_q <= off_cnt_q + 1'b1;
   end

   // R2: a path turns on only while no other path holds any stage.
   p_bbm_r2: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
      $rose(en_o) |-> !others_busy_i)
      else $error("gfm_path %0d: enabled while another path busy", K);

   // R7: a deselected path is fully released after STAGES falling edges.
   p_release_r7: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
      (off_cnt_q >= CW'(STAGES)) |-> !en_o)
      else $error("gfm_path %0d: still enabled after deselect", K);

endmodule

// File: rtl/gfm_merge.sv
`timescale 1ns/1ps
// Combines the gated sources into the output clock.
module gfm_merge #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] gated_i,
   output logic         clk_o
);

   assign clk_o = |gated_i;

endmodule

// File: rtl/clk_glitchfree_mux.sv
`timescale 1ns/1ps
module clk_glitchfree_mux #(
   parameter int unsigned N_SRC       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = gfm_pkg::gfm_sel_width(N_SRC)
) (
   input  logic [N_SRC-1:0] src_clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   output logic             clk_o,
   output logic [N_SRC-1:0] status_o
);

   if (N_SRC < 1 || N_SRC > gfm_pkg::GFM_MAX_SRC) begin : g_bad_count
      $error("clk_glitchfree_mux: N_SRC out of range");
   end

   if (N_SRC == 1) begin : g_single
      // One source: nothing to switch, pass it straight through.
      logic unused_inputs;
      assign unused_inputs = ^{sel_i, rst_ni};
      assign clk_o         = src_clk_i[0];
      assign status_o      = 1'b1;
   end else begin : g_multi
      logic [N_SRC-1:0] busy_vec;
      logic [N_SRC-1:0] en_vec;
      logic [N_SRC-1:0] gated_vec;
      logic [N_SRC-1:0] others_busy;

      for (genvar k = 0; k < N_SRC; k++) begin : g_path
         assign others_busy[k] = |(busy_vec & ~(N_SRC'(1) << k));

         gfm_path #(
            .K      (k),
            .SEL_W  (SEL_W),
            .STAGES (SYNC_STAGES)
         ) u_path (
            .src_clk_i     (src_clk_i[k]),
            .rst_ni        (rst_ni),
            .sel_i         (sel_i),
            .others_busy_i (others_busy[k]),
            .busy_o        (busy_vec[k]),
            .en_o          (en_vec[k]),
            .gclk_o        (gated_vec[k])
         );

         // R1: while path k is on, its high phase reaches the output.
         p_pass_r1: assert property (@(negedge src_clk_i[k]) disable iff (!rst_ni)
            en_vec[k] |-> clk_o)
            else $error("source %0d enabled but output low in its high phase", k);
      end

      gfm_merge #(.N(N_SRC)) u_merge (
         .gated_i (gated_vec),
         .clk_o   (clk_o)
      );

      assign status_o = en_vec;

      // R3: at most one source drives the output at any time.
      always_comb begin
         if (rst_ni === 1'b1) begin
            p_onehot_r3: assert ($onehot0(status_o))
               else $error("status not one-hot: %b", status_o);
         end
      end
   end

endmodule

// File: tb/clk_glitchfree_mux_bench.sv
`timescale 1ns/1ps
module clk_glitchfree_mux_bench;

   localparam int N     = 3;
   localparam int SEL_W = 2;

   typedef struct {
      logic [N-1:0] exp_status;
      real          period;
      bit           need_zero;
      bit           forbid_zero;
      string        tag;
   } item_t;

   logic             clk;
   logic [N-1:0]     src;
   logic             rst_n;
   logic [SEL_W-1:0] sel;
   logic             clko;
   logic [N-1:0]     status;
   logic             sel_one;
   logic             one_clk;
   logic [0:0]       one_status;

   int    checks = 0;
   int    fails  = 0;
   item_t q[$];
   bit    mon_busy  = 0;
   bit    mon_en    = 0;
   bit    zero_seen = 0;
   real   t_rise = 0.0, t_fall = 0.0, last_edge = 0.0;
   real   min_ok = 3.0;
   int    cur = 0, prev1 = 0, prev2 = 0;

   initial clk = 0;
   always #10 clk = ~clk;
   initial src = '0;
   always #5  src[0] = ~src[0];
   always #7  src[1] = ~src[1];
   always #13 src[2] = ~src[2];

   clk_glitchfree_mux #(.N_SRC(N), .SYNC_STAGES(2)) u_clk_glitchfree_mux (
      .src_clk_i (src),
      .rst_ni    (rst_n),
      .sel_i     (sel),
      .clk_o     (clko),
      .status_o  (status)
   );

   clk_glitchfree_mux #(.N_SRC(1), .SYNC_STAGES(2)) u_clk_glitchfree_mux_one (
      .src_clk_i (src[0:0]),
      .rst_ni    (rst_n),
      .sel_i     (sel_one),
      .clk_o     (one_clk),
      .status_o  (one_status)
   );

   function automatic real half_of(input int s);
      case (s)
         0:       return 5.0;
         1:       return 7.0;
         2:       return 13.0;
         default: return 1000.0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   // Pulse-width monitor (R4) and edge bookkeeping.
   always @(posedge clko) begin
      if (mon_en && t_fall > 0.0)
         chk(($realtime - t_fall) >= min_ok - 0.001,
             $sformatf("R4 low pulse actual %0.3f ns expected >= %0.3f ns", $realtime - t_fall, min_ok));
      t_rise    = $realtime;
      last_edge = $realtime;
   end
   always @(negedge clko) begin
      if (mon_en && t_rise > 0.0)
         chk(($realtime - t_rise) >= min_ok - 0.001,
             $sformatf("R4 high pulse actual %0.3f ns expected >= %0.3f ns", $realtime - t_rise, min_ok));
      t_fall    = $realtime;
      last_edge = $realtime;
   end

   // One-hot monitor (R3) and handover-zero tracking (R2).
   always @(status) begin
      if (rst_n === 1'b1) begin
         chk($onehot0(status), $sformatf("R3 status actual %b expected one-hot or zero", status));
         if (status == '0) zero_seen = 1;
      end
   end

   // Driver: writes a select code, optionally queues the expected outcome.
   task automatic request(input int s, input bit push, input bit need_zero,
                          input bit forbid_zero, input string tag);
      item_t it;
      real   m;
      wait (q.size() == 0 && !mon_busy);
      @(posedge clk);
      #0.3;
      prev2 = prev1; prev1 = cur; cur = s;
      m = half_of(prev2);
      if (half_of(prev1) < m) m = half_of(prev1);
      if (half_of(cur) < m)   m = half_of(cur);
      min_ok    = m;
      zero_seen = 0;
      sel       = SEL_W'(s);
      if (push) begin
         it.exp_status  = (s < N) ? N'(1) << s : '0;
         it.period      = (s < N) ? 2.0 * half_of(s) : 0.0;
         it.need_zero   = need_zero;
         it.forbid_zero = forbid_zero;
         it.tag         = tag;
         q.push_back(it);
      end
   endtask

   // Monitor: pops each expectation and compares once its deadline is met.
   initial begin
      item_t it;
      real   t1, t2;
      forever begin
         wait (q.size() != 0);
         mon_busy = 1;
         it = q.pop_front();
         #250;
         @(negedge clk);
         chk(status == it.exp_status,
             $sformatf("R5 %s status actual %b expected %b", it.tag, status, it.exp_status));
         if (it.need_zero)
            chk(zero_seen, $sformatf("R2 %s zero handover actual %0d expected 1", it.tag, zero_seen));
         if (it.forbid_zero)
            chk(!zero_seen, $sformatf("R6 %s status dropped actual %0d expected 0", it.tag, zero_seen));
         if (it.period > 0.0) begin
            @(posedge clko); t1 = $realtime;
            @(posedge clko); t2 = $realtime;
            chk((t2 - t1 - it.period) < 0.01 && (t1 - t2 + it.period) < 0.01,
                $sformatf("R1 %s period actual %0.3f expected %0.3f", it.tag, t2 - t1, it.period));
         end else begin
            chk(clko == 1'b0 && ($realtime - last_edge) > 150.0,
                $sformatf("R7 %s output actual %b idle %0.1f ns expected 0 idle > 150", it.tag,
                          clko, $realtime - last_edge));
         end
         mon_busy = 0;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      item_t it;
      rst_n   = 0;
      sel     = '0;
      sel_one = 0;
      #50.3;
      chk(status == '0, $sformatf("R8 reset status actual %b expected 000", status));
      chk(clko == 1'b0, $sformatf("R8 reset output actual %b expected 0", clko));
      chk(one_status == 1'b1, $sformatf("R9 reset status actual %b expected 1", one_status));
      #50;
      rst_n  = 1;
      mon_en = 1;
      request(0, 1, 0, 0, "lock 0 after reset R8");
      request(1, 1, 1, 0, "0 to 1");
      request(2, 1, 1, 0, "1 to 2");
      request(2, 1, 0, 1, "reselect 2 R6");
      request(0, 1, 1, 0, "2 to 0");
      request(3, 1, 0, 0, "code 3 R7");
      request(1, 1, 0, 0, "stopped to 1");
      request(0, 0, 0, 0, "rapid first");
      request(2, 1, 1, 0, "rapid 1 to 0 to 2 R10");
      request(1, 1, 1, 0, "2 to 1");

      // Asynchronous reset in the middle of operation (R8).
      wait (q.size() == 0 && !mon_busy);
      @(negedge clk);
      #0.3;
      mon_en = 0;
      rst_n  = 0;
      #1;
      chk(status == '0, $sformatf("R8 async reset status actual %b expected 000", status));
      chk(clko == 1'b0, $sformatf("R8 async reset output actual %b expected 0", clko));
      #20;
      rst_n     = 1;
      t_rise    = 0.0;
      t_fall    = 0.0;
      mon_en    = 1;
      zero_seen = 0;
      it.exp_status  = 3'b010;
      it.period      = 14.0;
      it.need_zero   = 0;
      it.forbid_zero = 0;
      it.tag         = "relock 1 after reset R8";
      q.push_back(it);
      wait (q.size() == 0 && !mon_busy);

      // Single-source variant (R9).
      for (int i = 0; i < 6; i++) begin
         sel_one = i[0];
         @(negedge clk);
         #2.3;
         chk(one_status == 1'b1, $sformatf("R9 status actual %b expected 1", one_status));
         chk(one_clk == src[0], $sformatf("R9 output actual %b expected %b", one_clk, src[0]));
         #3.0;
         chk(one_clk == src[0], $sformatf("R9 output actual %b expected %b", one_clk, src[0]));
      end

      summary();
      $finish;
   end

endmodule